// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out one-bit operations for a small controller core. Its one-bit accumulator is the carry flag. Each operation names one bit through an 8-bit bit address. That address points either at a bit in a sixteen-byte window of internal RAM or at a bit of a special-function register. The instruction decoder presents an operation code and a bit address for one cycle. The block then does the work, updates carry, decides whether a bit-test branch is taken, and pulses a done flag one cycle later.

The bytes behind the bits sit in a store outside the block. The store is read combinationally and written on the clock edge. The block drives the byte address and takes back the stored byte. When an operation changes a bit, the block returns the same byte with only that bit altered, and the store writes it at the edge that ends the operation. Some special-function bytes are I/O ports. For these, the store returns the output latch value, and a second input bus carries the sampled pin value of the same byte. Pure reads of a port bit use the pins. Read-modify-write operations on a port byte use the latch.

Branch target arithmetic, opcode decoding, instruction fetch and byte-wide arithmetic belong to other blocks.

Top module: `bool_bit_unit`

## Requirements
- R1: A bit address with bit 7 clear selects RAM byte 0x20 plus address[6:3] and bit index address[2:0]. For example, 0x7F selects bit 7 of byte 0x2F, and 0x17 selects bit 7 of byte 0x22.
- R2: A bit address with bit 7 set selects special-function byte {address[7:3], 3'b000} and bit index address[2:0]. For example, 0xD5 selects bit 5 of byte 0xD0, and 0xFF selects bit 7 of byte 0xF8.
- R3: Codes 1 (set carry), 2 (clear carry) and 3 (invert carry) change only carry and never write the store.
- R4: Codes 4 (set bit), 5 (clear bit) and 6 (invert bit) write back the addressed byte with only the addressed bit changed. Carry stays unchanged.
- R5: Code 7 copies the addressed bit into carry without writing the store. Code 8 writes carry into the addressed bit and leaves carry unchanged.
- R6: Codes 9, 10, 11 and 12 set carry to carry AND bit, carry AND NOT bit, carry OR bit, and carry OR NOT bit. None of them writes the store.
- R7: Code 13 reports branch taken when the bit is 1, and code 14 when the bit is 0. Neither writes the store or changes carry.
- R8: Code 15 (test-and-clear) on a bit that is 1 reports branch taken and clears that bit in the same operation. On a bit that is 0 it reports not taken and does not write.
- R9: The special-function bytes 0x80, 0x90, 0xA0 and 0xB0 are ports. Codes 7, 9–14 read a port bit from the pin bus. Codes 4–6, 8 and 15 read and rewrite a port byte from the latch value. Every other special-function byte is read from the store for every code.
- R10: Reset clears carry, done and branch taken. An operation strobed at one edge updates carry and the store at that edge. Done is then 1 for the next cycle, and branch taken is valid only while done is 1 (it is 0 for non-test codes).
- R11: Code 0 does nothing. Done still pulses, branch taken stays 0, carry is unchanged and there is no store write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 4 | Operation code (0–15) |
| bit_addr | input | 8 | Bit address |
| st_rd_data | input | 8 | Stored byte at st_addr (latch value for ports) |
| pin_data | input | 8 | Sampled pin value of the byte at st_addr |
| st_addr | output | 8 | Byte address into the store |
| st_wr_en | output | 1 | Store write enable, taken at the clock edge |
| st_wr_data | output | 8 | Byte to write back |
| carry | output | 1 | Carry flag (bit accumulator) |
| done | output | 1 | Operation completed last cycle |
| branch_taken | output | 1 | Test result, valid with done |

## Verification
The hardest case to reach from the ports is a port byte whose latch and pins disagree. That is the only case where reading the wrong source changes the result. The stimulus loads the latch with all ones and drives the pins to all zeros. It then runs plain tests, moves to carry, inversions and test-and-clear on that byte, so each source choice leaves a different byte in the store or a different carry. A non-port special-function byte gets the same disagreeing contents, which shows that the port decision depends on the byte address. A back-to-back pair, a write followed at once by a read of the same bit, shows that the second operation sees the byte written by the first.

// File: rtl/bbu_pkg.sv
// Package: shared widths and the operation code type of the single-bit
// processor. Assumes 8-bit bytes and 8-bit bit addresses.
package bbu_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int SLOT_W = ADDR_W - 1 - IDX_W;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_C_SET    = 4'd1,
        OP_C_CLR    = 4'd2,
        OP_C_INV    = 4'd3,
        OP_B_SET    = 4'd4,
        OP_B_CLR    = 4'd5,
        OP_B_INV    = 4'd6,
        OP_B_TO_C   = 4'd7,
        OP_C_TO_B   = 4'd8,
        OP_AND_C    = 4'd9,
        OP_ANDN_C   = 4'd10,
        OP_OR_C     = 4'd11,
        OP_ORN_C    = 4'd12,
        OP_TEST_1   = 4'd13,
        OP_TEST_0   = 4'd14,
        OP_TEST_CLR = 4'd15
    } bop_e;

    // True for codes that read the latch and may rewrite the byte.
    function automatic logic is_rmw(bop_e op);
        return (op == OP_B_SET) || (op == OP_B_CLR) || (op == OP_B_INV) ||
               (op == OP_C_TO_B) || (op == OP_TEST_CLR);
    endfunction
endpackage

// File: rtl/bbu_addr_map.sv
// Module: bbu_addr_map
// Turns a bit address into a byte address, a bit index and a port flag.
// The low half maps onto a RAM window starting at RAM_BASE. The high half
// maps onto special-function bytes aligned to 8. PORT_MASK marks which
// of the aligned slots are I/O ports. Purely combinational.
module bbu_addr_map
    import bbu_pkg::*;
#(
    parameter logic [ADDR_W-1:0]       RAM_BASE  = 8'h20,
    parameter logic [(1<<SLOT_W)-1:0]  PORT_MASK = 16'h000F
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              is_port
);
    localparam int PAD_W = ADDR_W - SLOT_W;

    logic              hi_region;
    logic [SLOT_W-1:0] slot;

    // Region select, slot number and bit position.
    always_comb begin
        hi_region = bit_addr[ADDR_W-1];
        slot      = bit_addr[ADDR_W-2:IDX_W];
        bit_idx   = bit_addr[IDX_W-1:0];
    end

    // Byte address per region, plus the port decision for the high region.
    always_comb begin
        if (hi_region) begin
            byte_addr = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
            is_port   = PORT_MASK[slot];
        end else begin
            byte_addr = RAM_BASE + {{PAD_W{1'b0}}, slot};
            is_port   = 1'b0;
        end
    end
endmodule

// File: rtl/bbu_bit_merge.sv
// Module: bbu_bit_merge
// Puts one new bit value into a byte at a given index and passes the other
// bits through unchanged. Purely combinational.
module bbu_bit_merge
    import bbu_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic              val,
    output logic [BYTE_W-1:0] byte_out
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        // Bit i takes the new value only when the index selects it.
        always_comb byte_out[i] = (idx == IDX_W'(i)) ? val : byte_in[i];
    end
endmodule

// File: rtl/bbu_eval.sv
// Module: bbu_eval
// Works out the result of one operation: next carry, whether the addressed
// bit is written and with what value, and the branch decision. It takes the
// addressed bit twice, once from the plain-read source (pins for ports) and
// once from the latch. Purely combinational, and not gated by the strobe.
module bbu_eval
    import bbu_pkg::*;
(
    input  bop_e op,
    input  logic carry_q,
    input  logic rd_plain,
    input  logic rd_latch,
    output logic carry_nxt,
    output logic bit_wr,
    output logic bit_val,
    output logic taken
);
    // Per-code result; defaults keep all state unchanged.
    always_comb begin
        carry_nxt = carry_q;
        bit_wr    = 1'b0;
        bit_val   = rd_latch;
        taken     = 1'b0;
        unique case (op)
            OP_C_SET:    carry_nxt = 1'b1;
            OP_C_CLR:    carry_nxt = 1'b0;
            OP_C_INV:    carry_nxt = ~carry_q;
            OP_B_SET:    begin bit_wr = 1'b1; bit_val = 1'b1;      end
            OP_B_CLR:    begin bit_wr = 1'b1; bit_val = 1'b0;      end
            OP_B_INV:    begin bit_wr = 1'b1; bit_val = ~rd_latch; end
            OP_B_TO_C:   carry_nxt = rd_plain;
            OP_C_TO_B:   begin bit_wr = 1'b1; bit_val = carry_q;   end
            OP_AND_C:    carry_nxt = carry_q & rd_plain;
            OP_ANDN_C:   carry_nxt = carry_q & ~rd_plain;
            OP_OR_C:     carry_nxt = carry_q | rd_plain;
            OP_ORN_C:    carry_nxt = carry_q | ~rd_plain;
            OP_TEST_1:   taken = rd_plain;
            OP_TEST_0:   taken = ~rd_plain;
            OP_TEST_CLR: begin taken = rd_latch; bit_wr = rd_latch; bit_val = 1'b0; end
            default:     ;
        endcase
    end
endmodule

// File: rtl/bool_bit_unit.sv
// Module: bool_bit_unit (top)
// Single-bit processor with carry as its accumulator. It assumes an
// external byte store that is read combinationally at st_addr and written
// on the clock edge when st_wr_en is high. For port bytes, st_rd_data is
// the output latch and pin_data is the sampled pins. One operation per
// op_valid cycle. Results appear on the following cycle with done.
module bool_bit_unit
    import bbu_pkg::*;
#(
    parameter logic [ADDR_W-1:0]      RAM_BASE  = 8'h20,
    parameter logic [(1<<SLOT_W)-1:0] PORT_MASK = 16'h0055
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [BYTE_W-1:0] st_rd_data,
    input  logic [BYTE_W-1:0] pin_data,
    output logic [ADDR_W-1:0] st_addr,
    output logic              st_wr_en,
    output logic [BYTE_W-1:0] st_wr_data,
    output logic              carry,
    output logic              done,
    output logic              branch_taken
);
    localparam int RAM_BYTES = 1 << SLOT_W;

    bop_e             op;
    logic [IDX_W-1:0] bit_idx;
    logic             is_port;
    logic             rd_latch, rd_plain;
    logic             carry_nxt, bit_wr, bit_val, taken;

    // Decode the operation code into the shared type.
    always_comb op = bop_e'(op_code);

    bbu_addr_map #(
        .RAM_BASE  (RAM_BASE),
        .PORT_MASK (PORT_MASK)
    ) u_map (
        .bit_addr  (bit_addr),
        .byte_addr (st_addr),
        .bit_idx   (bit_idx),
        .is_port   (is_port)
    );

    // Pick the bit sources: the latch always, the pins for plain port reads.
    always_comb begin
        rd_latch = st_rd_data[bit_idx];
        rd_plain = is_port ? pin_data[bit_idx] : rd_latch;
    end

    bbu_eval u_eval (
        .op        (op),
        .carry_q   (carry),
        .rd_plain  (rd_plain),
        .rd_latch  (rd_latch),
        .carry_nxt (carry_nxt),
        .bit_wr    (bit_wr),
        .bit_val   (bit_val),
        .taken     (taken)
    );

    bbu_bit_merge u_merge (
        .byte_in  (st_rd_data),
        .idx      (bit_idx),
        .val      (bit_val),
        .byte_out (st_wr_data)
    );

    // Write back only while an operation is strobed.
    always_comb st_wr_en = op_valid & bit_wr;

    // Carry, done and branch result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry        <= 1'b0;
            done         <= 1'b0;
            branch_taken <= 1'b0;
        end else begin
            done         <= op_valid;
            branch_taken <= op_valid & taken;
            if (op_valid) carry <= carry_nxt;
        end
    end

    // ---------------- assertions ----------------
    p_ram_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !bit_addr[ADDR_W-1] |->
            (st_addr >= RAM_BASE) && (st_addr < RAM_BASE + ADDR_W'(RAM_BYTES)));

    p_sfr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && bit_addr[ADDR_W-1] |->
            st_addr[ADDR_W-1] && (st_addr[IDX_W-1:0] == '0));

    p_carry_op_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op == OP_C_SET || op == OP_C_CLR || op == OP_C_INV) |-> !st_wr_en);

    p_single_bit_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> $countones(st_wr_data ^ st_rd_data) <= 1);

    p_carry_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op == OP_B_SET || op == OP_B_CLR || op == OP_B_INV) |=> $stable(carry));

    p_test_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op == OP_TEST_1 || op == OP_TEST_0) |-> !st_wr_en);

    p_clear_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_TEST_CLR && st_wr_en |-> (st_wr_data & ~st_rd_data) == '0);

    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    p_taken_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> done);

    p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_NOP |-> !st_wr_en);

    p_plain_port_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !is_rmw(op) |-> !st_wr_en);
endmodule

// File: tb/bool_bit_unit_tb_top.sv
// Directed bench for bool_bit_unit. It models the byte store and the pins.
module bool_bit_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] bit_addr = 8'd0;
    logic [7:0] st_rd_data, pin_data, st_addr, st_wr_data;
    logic       st_wr_en, carry, done, branch_taken;

    logic [7:0] mem  [256];
    logic [7:0] pins [256];
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = 8'd0, pre_data = 8'd0;

    int  n_checks = 0, n_errors = 0;
    bit  finished = 1'b0;
    logic [7:0] last_addr;
    logic       last_wr;

    always #2 clk = ~clk;

    assign st_rd_data = mem[st_addr];
    assign pin_data   = pins[st_addr];

    // Store model: bench preload or design write-back.
    always @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_data;
        else if (st_wr_en) mem[st_addr] <= st_wr_data;
    end

    bool_bit_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_addr(bit_addr), .st_rd_data(st_rd_data), .pin_data(pin_data),
        .st_addr(st_addr), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .carry(carry), .done(done), .branch_taken(branch_taken)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // Strobe one operation; afterwards done, carry, taken and store are settled.
    task automatic do_op(input logic [3:0] c, input logic [7:0] a);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; bit_addr = a;
        #1;
        last_addr = st_addr;
        last_wr   = st_wr_en;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic set_carry(input bit v);
        do_op(v ? 4'd1 : 4'd2, 8'h00);
    endtask

    task automatic t_reset;
        eq("R10 reset carry", carry, 0);
        eq("R10 reset done", done, 0);
        eq("R10 reset taken", branch_taken, 0);
    endtask

    task automatic t_map_low;
        preload(8'h2F, 8'h00); preload(8'h22, 8'h00); preload(8'h2E, 8'h00);
        do_op(4'd4, 8'h7F);
        eq("R1 addr 7F byte", last_addr, 8'h2F);
        eq("R1 addr 7F bit7", mem[8'h2F], 8'h80);
        do_op(4'd4, 8'h17);
        eq("R1 addr 17 bit7", mem[8'h22], 8'h80);
        eq("R1 neighbour byte", mem[8'h2E], 8'h00);
    endtask

    task automatic t_map_high;
        preload(8'hD0, 8'h00); preload(8'hF8, 8'h00);
        do_op(4'd4, 8'hD5);
        eq("R2 addr D5 byte", last_addr, 8'hD0);
        eq("R2 addr D5 bit5", mem[8'hD0], 8'h20);
        do_op(4'd4, 8'hFF);
        eq("R2 addr FF bit7", mem[8'hF8], 8'h80);
    endtask

    task automatic t_carry_ops;
        do_op(4'd1, 8'h00);
        eq("R3 set carry", carry, 1);
        eq("R3 set no write", last_wr, 0);
        do_op(4'd3, 8'h00);
        eq("R3 invert carry", carry, 0);
        do_op(4'd3, 8'h00);
        eq("R3 invert again", carry, 1);
        do_op(4'd2, 8'h00);
        eq("R3 clear carry", carry, 0);
        eq("R3 clear no write", last_wr, 0);
    endtask

    task automatic t_bit_ops;
        preload(8'h25, 8'hA5);
        set_carry(1);
        do_op(4'd5, 8'h28);
        eq("R4 clear bit0", mem[8'h25], 8'hA4);
        do_op(4'd6, 8'h29);
        eq("R4 invert bit1", mem[8'h25], 8'hA6);
        do_op(4'd6, 8'h2F);
        eq("R4 invert bit7", mem[8'h25], 8'h26);
        eq("R4 carry kept", carry, 1);
    endtask

    task automatic t_moves;
        preload(8'h26, 8'h00);
        set_carry(1);
        do_op(4'd8, 8'h30);
        eq("R5 carry to bit", mem[8'h26], 8'h01);
        eq("R5 carry kept", carry, 1);
        do_op(4'd7, 8'h31);
        eq("R5 bit to carry 0", carry, 0);
        eq("R5 no write", last_wr, 0);
        do_op(4'd7, 8'h30);
        eq("R5 bit to carry 1", carry, 1);
    endtask

    task automatic t_logic;
        preload(8'h27, 8'h01);          // bit 0x38 = 1, bit 0x39 = 0
        set_carry(1);
        do_op(4'd9, 8'h39);
        eq("R6 and 1&0", carry, 0);
        do_op(4'd12, 8'h39);
        eq("R6 orn 0|~0", carry, 1);
        do_op(4'd10, 8'h38);
        eq("R6 andn 1&~1", carry, 0);
        do_op(4'd11, 8'h38);
        eq("R6 or 0|1", carry, 1);
        do_op(4'd10, 8'h39);
        eq("R6 andn 1&~0", carry, 1);
        eq("R6 no write", last_wr, 0);
        do_op(4'd12, 8'h38);
        eq("R6 orn 1|~1", carry, 1);
        eq("R6 byte kept", mem[8'h27], 8'h01);
    endtask

    task automatic t_tests;
        set_carry(0);
        do_op(4'd13, 8'h38);
        eq("R7 test1 taken", branch_taken, 1);
        eq("R7 taken with done", done, 1);
        do_op(4'd13, 8'h39);
        eq("R7 test1 not taken", branch_taken, 0);
        do_op(4'd14, 8'h39);
        eq("R7 test0 taken", branch_taken, 1);
        eq("R7 no write", last_wr, 0);
        eq("R7 carry kept", carry, 0);
        do_op(4'd1, 8'h38);
        eq("R10 taken 0 for non-test", branch_taken, 0);
    endtask

    task automatic t_test_clear;
        preload(8'h28, 8'h81);
        do_op(4'd15, 8'h47);
        eq("R8 taken on set bit", branch_taken, 1);
        eq("R8 bit cleared", mem[8'h28], 8'h01);
        do_op(4'd15, 8'h47);
        eq("R8 not taken on clear bit", branch_taken, 0);
        eq("R8 no write when clear", last_wr, 0);
        eq("R8 byte unchanged", mem[8'h28], 8'h01);
    endtask

    task automatic t_port;
        preload(8'h90, 8'hFF); pins[8'h90] = 8'h00;
        preload(8'h88, 8'hFF); pins[8'h88] = 8'h00;
        do_op(4'd13, 8'h90);
        eq("R9 test reads pins", branch_taken, 0);
        do_op(4'd6, 8'h91);
        eq("R9 invert uses latch", mem[8'h90], 8'hFD);
        set_carry(1);
        do_op(4'd7, 8'h92);
        eq("R9 move reads pins", carry, 0);
        do_op(4'd15, 8'h97);
        eq("R9 test-clear latch taken", branch_taken, 1);
        eq("R9 test-clear latch byte", mem[8'h90], 8'h7D);
        do_op(4'd7, 8'h88);
        eq("R9 non-port uses store", carry, 1);
    endtask

    task automatic t_timing;
        preload(8'h2A, 8'h00);
        set_carry(0);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd4; bit_addr = 8'h50;
        @(negedge clk);
        eq("R10 done after first", done, 1);
        op_code = 4'd7; bit_addr = 8'h50;
        @(negedge clk);
        op_valid = 1'b0;
        eq("R10 back-to-back read", carry, 1);
        eq("R10 done second", done, 1);
        @(negedge clk);
        eq("R10 done drops", done, 0);
        do_op(4'd0, 8'h50);
        eq("R11 nop done", done, 1);
        eq("R11 nop not taken", branch_taken, 0);
        eq("R11 nop carry", carry, 1);
        eq("R11 nop no write", last_wr, 0);
        eq("R11 nop byte", mem[8'h2A], 8'h01);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pins[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_map_low;
        t_map_high;
        t_carry_ops;
        t_bit_ops;
        t_moves;
        t_logic;
        t_tests;
        t_test_clear;
        t_port;
        t_timing;
        summary;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary;
    end
endmodule